// File: doc/BRIEF.md
# Packed Decimal Byte Arithmetic Unit

This unit does decimal arithmetic on one byte that holds two packed BCD digits, a tens digit in bits 7:4 and a units digit in bits 3:0. It has three operations: add, subtract and negate. Each one also takes a one-bit extend input that acts as the incoming decimal carry or borrow. The unit returns the result byte together with updated extend, carry and zero flags.

A number longer than one byte is processed one byte at a time, starting with the least significant byte. The caller feeds the extend output of each byte into the extend input of the next. The zero flag only ever gets cleared along such a chain, so after the last byte it reports whether the whole number is zero. Before the first byte the caller sets the zero input to 1 and the extend input to 0.

Operations are accepted on a single-cycle strobe. The result and the flags come out of registers one clock later, together with a one-cycle valid pulse.

Top module: `bcd_byte_alu`

## Requirements
- R1: Operation code 2'b00 adds: result = destination + source + extend, worked out in decimal. Example: 0x45 + 0x38 with extend 0 gives 0x83, and 0x09 + 0x01 gives 0x10.
- R2: Operation code 2'b01 subtracts: result = destination - source - extend, in decimal, wrapping modulo 100. Example: 0x00 - 0x01 gives 0x99 with a borrow.
- R3: Operation code 2'b10 negates the destination byte: result = 0 - destination - extend. With extend 0 this is the ten's complement and with extend 1 it is the nine's complement. The source byte has no effect on the result.
- R4: The extend output and the carry output are both 1 exactly when the byte produces a decimal carry out (add) or a borrow out (subtract or negate). Otherwise both are 0.
- R5: The zero output equals the zero input AND (result == 0x00). A nonzero result therefore clears it, and a zero result passes the input value through.
- R6: The output valid signal is high for exactly one cycle. It rises on the clock edge after the edge that samples the input strobe, and the result and flags are valid in that same cycle.
- R7: While the input strobe is low, the result byte and the three flags keep their last values and the output valid signal stays low, whatever the other inputs do.
- R8: A synchronous active-high reset clears the result, all three flags and the output valid signal to 0.
- R9: Operation code 2'b11 behaves exactly like add.
- R10: When both operands hold only digits 0 to 9, every digit of the result is also in the range 0 to 9.
- R11: An operand containing digits 10 to 15 gives an unspecified result. It still produces one output valid pulse and does not disturb any operation that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Start-operation strobe |
| in_op | input | 2 | Operation code: 00 add, 01 subtract, 10 negate, 11 add |
| in_src | input | 8 | Source byte, two packed BCD digits |
| in_dst | input | 8 | Destination byte; the operand of negate |
| in_x | input | 1 | Incoming extend (decimal carry or borrow) |
| in_z | input | 1 | Incoming zero flag |
| out_vld | output | 1 | Result valid pulse |
| out_res | output | 8 | Result byte |
| out_x | output | 1 | Extend flag out |
| out_c | output | 1 | Carry flag out |
| out_z | output | 1 | Zero flag out |

## Verification
Add is tried with sums that need no correction, with sums that carry only out of the units digit, and with sums that reach 100 or 199. These cases separate a missing per-digit correction from a missing byte carry. Subtract and negate are tried with and without an incoming borrow and at zero, which tells the ten's complement apart from the nine's complement and shows whether the borrow chain works across both digits. A two-byte chain and a coarse grid over all decimal operand pairs, checked against a decimal integer model, show the extend and zero flags linking correctly from byte to byte. Separate patterns cover the ignored source byte, the reserved code and non-decimal digits.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        BOP_ADD = 2'b00,
        BOP_SUB = 2'b01,
        BOP_NEG = 2'b10,
        BOP_ALT = 2'b11
    } bcd_op_e;

    // Control derived from the operation code
    typedef struct packed {
        logic subtract;     // digit cells borrow instead of carry
        logic neg_form;     // minuend forced to zero, destination becomes subtrahend
    } op_ctrl_t;

    // Flag bundle produced after each byte
    typedef struct packed {
        logic x;
        logic c;
        logic z;
    } bcd_flags_t;

    function automatic op_ctrl_t decode_op(logic [1:0] code);
        op_ctrl_t ctl;
        case (code)
            2'b01:   ctl = '{subtract: 1'b1, neg_form: 1'b0};
            2'b10:   ctl = '{subtract: 1'b1, neg_form: 1'b1};
            default: ctl = '{subtract: 1'b0, neg_form: 1'b0};
        endcase
        return ctl;
    endfunction

    // A five-bit digit sum needs correction once it passes nine
    function automatic logic sum_over_nine(logic [DIGIT_W:0] s);
        return (s > 5'd9);
    endfunction

endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
    import bcd_pkg::*;
(
    input  logic [DIGIT_W-1:0] a,
    input  logic [DIGIT_W-1:0] b,
    input  logic               cin,
    input  logic               subtract,
    output logic [DIGIT_W-1:0] d,
    output logic               cout
);
    localparam logic [DIGIT_W-1:0] ADJ = 4'd6;

    logic [DIGIT_W:0] raw;

    always_comb begin
        if (subtract) begin
            raw  = {1'b0, a} - {1'b0, b} - {{DIGIT_W{1'b0}}, cin};
            cout = raw[DIGIT_W];
            d    = cout ? (raw[DIGIT_W-1:0] - ADJ) : raw[DIGIT_W-1:0];
        end else begin
            raw  = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
            cout = sum_over_nine(raw);
            d    = cout ? (raw[DIGIT_W-1:0] + ADJ) : raw[DIGIT_W-1:0];
        end
    end
endmodule

// File: rtl/bcd_byte_chain.sv
module bcd_byte_chain
    import bcd_pkg::*;
#(
    parameter int NDIG = 2,
    localparam int DW  = NDIG * DIGIT_W
) (
    input  logic [1:0]    op,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] dst,
    input  logic          x_in,
    output logic [DW-1:0] res,
    output logic          carry
);
    op_ctrl_t      ctl;
    logic [DW-1:0] opa;
    logic [DW-1:0] opb;
    logic [NDIG:0] link;

    always_comb begin
        ctl = decode_op(op);
        opa = ctl.neg_form ? '0  : dst;
        opb = ctl.neg_form ? dst : src;
    end

    assign link[0] = x_in;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        bcd_digit_cell u_cell (
            .a        (opa[g*DIGIT_W +: DIGIT_W]),
            .b        (opb[g*DIGIT_W +: DIGIT_W]),
            .cin      (link[g]),
            .subtract (ctl.subtract),
            .d        (res[g*DIGIT_W +: DIGIT_W]),
            .cout     (link[g+1])
        );
    end

    assign carry = link[NDIG];
endmodule

// File: rtl/bcd_flag_unit.sv
module bcd_flag_unit
    import bcd_pkg::*;
#(
    parameter int NDIG = 2,
    localparam int DW  = NDIG * DIGIT_W
) (
    input  logic [DW-1:0] res,
    input  logic          carry,
    input  logic          z_in,
    output bcd_flags_t    flags
);
    always_comb begin
        flags.x = carry;
        flags.c = carry;
        flags.z = z_in & ~(|res);
    end
endmodule

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu
    import bcd_pkg::*;
#(
    parameter int NDIG = 2,
    localparam int DW  = NDIG * DIGIT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [1:0]    in_op,
    input  logic [DW-1:0] in_src,
    input  logic [DW-1:0] in_dst,
    input  logic          in_x,
    input  logic          in_z,
    output logic          out_vld,
    output logic [DW-1:0] out_res,
    output logic          out_x,
    output logic          out_c,
    output logic          out_z
);
    logic [DW-1:0] res_d;
    logic          carry_d;
    bcd_flags_t    flags_d;
    bcd_flags_t    flags_q;
    logic [DW-1:0] res_q;
    logic          vld_q;

    bcd_byte_chain #(.NDIG(NDIG)) u_chain (
        .op    (in_op),
        .src   (in_src),
        .dst   (in_dst),
        .x_in  (in_x),
        .res   (res_d),
        .carry (carry_d)
    );

    bcd_flag_unit #(.NDIG(NDIG)) u_flags (
        .res   (res_d),
        .carry (carry_d),
        .z_in  (in_z),
        .flags (flags_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q   <= 1'b0;
            res_q   <= '0;
            flags_q <= '0;
        end else begin
            vld_q <= in_vld;
            if (in_vld) begin
                res_q   <= res_d;
                flags_q <= flags_d;
            end
        end
    end

    assign out_vld = vld_q;
    assign out_res = res_q;
    assign out_x   = flags_q.x;
    assign out_c   = flags_q.c;
    assign out_z   = flags_q.z;
endmodule

// File: rtl/bcd_byte_alu_chk.sv
module bcd_byte_alu_chk
    import bcd_pkg::*;
#(
    parameter int NDIG = 2,
    localparam int DW  = NDIG * DIGIT_W
) (
    input logic          clk,
    input logic          rst,
    input logic          in_vld,
    input logic [1:0]    in_op,
    input logic [DW-1:0] in_src,
    input logic [DW-1:0] in_dst,
    input logic          in_x,
    input logic          in_z,
    input logic          out_vld,
    input logic [DW-1:0] out_res,
    input logic          out_x,
    input logic          out_c,
    input logic          out_z
);
    function automatic logic digits_ok(logic [DW-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NDIG; i++)
            if (v[i*DIGIT_W +: DIGIT_W] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);                                              // R6
    AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);                                            // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(out_res) && $stable(out_x) && $stable(out_c) && $stable(out_z))); // R7
    AST_ZERO_STAYS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !in_z) |=> !out_z);                                    // R5
    AST_NONZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (out_vld && out_res != '0) |-> !out_z);                           // R5
    AST_DIGITS_DECIMAL: assert property (@(posedge clk) disable iff (rst)
        (in_vld && digits_ok(in_src) && digits_ok(in_dst)) |=> digits_ok(out_res)); // R10
    AST_ADD_ZERO_IDENT: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_op == BOP_ADD && !in_x && in_src == '0 && digits_ok(in_dst))
        |=> (out_res == $past(in_dst) && !out_c && !out_x));              // R1
endmodule

bind bcd_byte_alu bcd_byte_alu_chk #(.NDIG(NDIG)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_op   (in_op),
    .in_src  (in_src),
    .in_dst  (in_dst),
    .in_x    (in_x),
    .in_z    (in_z),
    .out_vld (out_vld),
    .out_res (out_res),
    .out_x   (out_x),
    .out_c   (out_c),
    .out_z   (out_z)
);

// File: tb/tb_bcd_byte_alu.sv
`timescale 1ns/1ps
module tb_bcd_byte_alu;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_vld;
    logic [1:0] in_op;
    logic [7:0] in_src;
    logic [7:0] in_dst;
    logic       in_x;
    logic       in_z;
    logic       out_vld;
    logic [7:0] out_res;
    logic       out_x;
    logic       out_c;
    logic       out_z;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    bcd_byte_alu dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op),
        .in_src(in_src), .in_dst(in_dst), .in_x(in_x), .in_z(in_z),
        .out_vld(out_vld), .out_res(out_res), .out_x(out_x),
        .out_c(out_c), .out_z(out_z)
    );

    // {op, dst, src, x, z_in, exp_res, exp_c, exp_z}
    localparam int NV = 16;
    localparam logic [29:0] VEC [NV] = '{
        {2'd0, 8'h45, 8'h38, 1'b0, 1'b1, 8'h83, 1'b0, 1'b0},
        {2'd0, 8'h99, 8'h01, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1},
        {2'd0, 8'h99, 8'h99, 1'b1, 1'b1, 8'h99, 1'b1, 1'b0},
        {2'd0, 8'h09, 8'h01, 1'b0, 1'b1, 8'h10, 1'b0, 1'b0},
        {2'd0, 8'h00, 8'h00, 1'b1, 1'b1, 8'h01, 1'b0, 1'b0},
        {2'd1, 8'h45, 8'h38, 1'b0, 1'b1, 8'h07, 1'b0, 1'b0},
        {2'd1, 8'h10, 8'h01, 1'b0, 1'b1, 8'h09, 1'b0, 1'b0},
        {2'd1, 8'h00, 8'h01, 1'b0, 1'b1, 8'h99, 1'b1, 1'b0},
        {2'd1, 8'h50, 8'h50, 1'b1, 1'b1, 8'h99, 1'b1, 1'b0},
        {2'd1, 8'h27, 8'h27, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1},
        {2'd2, 8'h01, 8'h55, 1'b0, 1'b1, 8'h99, 1'b1, 1'b0},
        {2'd2, 8'h01, 8'h00, 1'b1, 1'b1, 8'h98, 1'b1, 1'b0},
        {2'd2, 8'h00, 8'h77, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
        {2'd2, 8'h00, 8'h00, 1'b1, 1'b1, 8'h99, 1'b1, 1'b0},
        {2'd2, 8'h37, 8'h12, 1'b0, 1'b1, 8'h63, 1'b1, 1'b0},
        {2'd2, 8'h37, 8'h99, 1'b1, 1'b1, 8'h62, 1'b1, 1'b0}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drives one strobe and returns once the registered outputs are settled
    task automatic run_op(input logic [1:0] op, input logic [7:0] d, input logic [7:0] s,
                          input logic x, input logic z);
        @(negedge clk);
        in_op = op; in_dst = d; in_src = s; in_x = x; in_z = z; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    function automatic int to_dec(logic [7:0] v);
        return 10 * int'(v[7:4]) + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] to_bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int model(input logic [1:0] op, input logic [7:0] d,
                                 input logic [7:0] s, input logic x);
        int v;
        case (op)
            2'd1:    v = to_dec(d) - to_dec(s) - int'(x);
            2'd2:    v = 0 - to_dec(d) - int'(x);
            default: v = to_dec(d) + to_dec(s) + int'(x);
        endcase
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_vld = 1'b1; in_op = 2'd0; in_src = 8'h99; in_dst = 8'h99;
        in_x = 1'b1; in_z = 1'b1;
        repeat (3) @(negedge clk);
        // R8: outputs cleared while reset is held, even with a strobe present
        check({out_vld, out_res, out_x, out_c, out_z} == 12'h0, "R8 reset state",
              int'({out_vld, out_res, out_x, out_c, out_z}), 0);
        in_vld = 1'b0;
        rst = 1'b0;

        // Table walk: R1 R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            v = VEC[i];
            run_op(v[29:28], v[27:20], v[19:12], v[11], v[10]);
            check(out_vld == 1'b1, "R6 valid pulse", int'(out_vld), 1);
            check(out_res == v[9:2], "R1/R2/R3 table result", int'(out_res), int'(v[9:2]));
            check(out_c == v[1] && out_x == v[1], "R4 carry/extend", int'({out_x, out_c}), int'({v[1], v[1]}));
            check(out_z == v[0], "R5 zero flag", int'(out_z), int'(v[0]));
        end

        // R6: pulse lasts one cycle
        @(negedge clk);
        check(out_vld == 1'b0, "R6 single pulse", int'(out_vld), 0);

        // R7: idle inputs ignored
        run_op(2'd0, 8'h12, 8'h34, 1'b0, 1'b1);
        in_dst = 8'h77; in_src = 8'h88; in_op = 2'd1; in_x = 1'b1; in_z = 1'b0;
        repeat (3) @(negedge clk);
        check(out_vld == 1'b0, "R7 no pulse while idle", int'(out_vld), 0);
        check(out_res == 8'h46 && out_z == 1'b0 && out_c == 1'b0, "R7 hold",
              int'({out_res, out_z, out_c}), int'({8'h46, 1'b0, 1'b0}));

        // R3: source byte has no effect on negate
        run_op(2'd2, 8'h25, 8'h00, 1'b0, 1'b1);
        check(out_res == 8'h75, "R3 negate src 00", int'(out_res), 8'h75);
        run_op(2'd2, 8'h25, 8'hFF, 1'b0, 1'b1);
        check(out_res == 8'h75, "R3 negate src ignored", int'(out_res), 8'h75);

        // R9: reserved code adds
        run_op(2'd3, 8'h45, 8'h38, 1'b1, 1'b1);
        check(out_res == 8'h84 && out_c == 1'b0, "R9 code 11 adds",
              int'({out_res, out_c}), int'({8'h84, 1'b0}));

        // R4 R5: two-byte chain 0x1299 + 0x0001 = 0x1300
        run_op(2'd0, 8'h99, 8'h01, 1'b0, 1'b1);
        check(out_res == 8'h00 && out_x == 1'b1 && out_z == 1'b1, "R4 chain low byte",
              int'({out_res, out_x, out_z}), int'({8'h00, 1'b1, 1'b1}));
        begin
            logic xl, zl;
            xl = out_x; zl = out_z;
            run_op(2'd0, 8'h12, 8'h00, xl, zl);
        end
        check(out_res == 8'h13 && out_x == 1'b0 && out_z == 1'b0, "R5 chain high byte",
              int'({out_res, out_x, out_z}), int'({8'h13, 1'b0, 1'b0}));

        // R11: non-decimal digits do not disturb later work
        run_op(2'd0, 8'hFF, 8'hFF, 1'b1, 1'b1);
        check(out_vld == 1'b1, "R11 pulse on bad digits", int'(out_vld), 1);
        run_op(2'd1, 8'h3A, 8'hCF, 1'b1, 1'b1);
        run_op(2'd0, 8'h21, 8'h21, 1'b0, 1'b1);
        check(out_res == 8'h42 && out_c == 1'b0, "R11 recovery",
              int'({out_res, out_c}), int'({8'h42, 1'b0}));

        // Grid against decimal model: R1 R2 R3 R4 R10
        for (int op = 0; op < 3; op++)
            for (int dv = 0; dv < 100; dv += 7)
                for (int sv = 0; sv < 100; sv += 13)
                    for (int xv = 0; xv < 2; xv++) begin
                        int m;
                        logic [7:0] er;
                        logic ec;
                        m  = model(2'(op), to_bcd(dv), to_bcd(sv), 1'(xv));
                        ec = (m < 0) || (m > 99);
                        er = to_bcd((m + 200) % 100);
                        run_op(2'(op), to_bcd(dv), to_bcd(sv), 1'(xv), 1'b1);
                        check(out_res == er, "R10 grid result", int'(out_res), int'(er));
                        check(out_c == ec && out_x == ec, "R4 grid carry",
                              int'({out_x, out_c}), int'({ec, ec}));
                    end

        // R8: reset mid-run
        run_op(2'd0, 8'h50, 8'h49, 1'b0, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check({out_vld, out_res, out_x, out_c, out_z} == 12'h0, "R8 reset mid-run",
              int'({out_vld, out_res, out_x, out_c, out_z}), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule